// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block is the processor-side controller for instructions handed to an attached coprocessor. When such an instruction is about to enter Execute, the sequencer reads a two-bit reply from the coprocessor's decode-stage handshake. From then on, for as long as the instruction keeps needing Execute cycles, it reads the execute-stage handshake. From these replies it decides whether to stall in a busy-wait loop, carry on with a run of data beats, finish, or ask for the undefined-instruction trap.

Two other events cut an instruction short. An interrupt that arrives while the sequencer is busy-waiting withdraws the pass strobe and abandons the instruction. A data abort raised by the preceding instruction, if it is reported during the first Execute cycle, produces a one-cycle late-cancel strobe in the following cycle and kills the instruction. Each outcome appears as a single-cycle pulse: trap, completion, abandonment or late cancel.

Top module: `cphs_seq`

## Requirements
- R1: The handshake codes are WAIT=2'b00, GO=2'b01, ABSENT=2'b10 and LAST=2'b11. If an instruction is issued from idle with decode handshake ABSENT, `undef_trap_o` is high for exactly the next cycle and `pass_o` stays low.
- R2: If an instruction is issued with decode handshake WAIT, then from the next cycle `stall_o` and `pass_o` are both high in every cycle in which the execute handshake reads WAIT.
- R3: When the execute handshake reads LAST, the next cycle is one final Execute cycle, with `pass_o` high and `stall_o` low. `done_o` pulses for one cycle in the cycle after that.
- R4: If the execute handshake reads ABSENT while the sequencer is busy-waiting or transferring, `undef_trap_o` pulses in the next cycle and `pass_o` falls. No completion follows.
- R5: An interrupt sampled during busy-wait ends the instruction. In the next cycle `pass_o` and `stall_o` are low and `abandon_o` pulses for one cycle. No trap and no completion is reported for that instruction.
- R6: An interrupt sampled while GO beats are being transferred has no effect. The instruction completes with `done_o` and `abandon_o` never rises.
- R7: A sequence of N GO replies followed by LAST keeps `pass_o` high for N+1 cycles after the issue edge and gives exactly one `done_o` pulse.
- R8: A prior-abort flag sampled in the first Execute cycle raises `late_cancel_o` for one cycle in the following cycle, drops `pass_o`, and suppresses completion. The same flag in any later Execute cycle is ignored.
- R9: An issue request made while an instruction is in flight is ignored, together with its decode handshake. At most one of the four outcome pulses is high in any cycle.
- R10: After a synchronous reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | A coprocessor instruction enters Execute next cycle |
| dec_hs_i | input | 2 | Decode-stage handshake from coprocessor |
| exe_hs_i | input | 2 | Execute-stage handshake from coprocessor |
| irq_i | input | 1 | Interrupt request |
| prior_abort_i | input | 1 | Preceding instruction raised a data abort |
| pass_o | output | 1 | Instruction is live in Execute |
| stall_o | output | 1 | Core is busy-waiting on the coprocessor |
| late_cancel_o | output | 1 | One-cycle cancel of the current coprocessor instruction |
| undef_trap_o | output | 1 | One-cycle undefined-instruction trap request |
| done_o | output | 1 | One-cycle instruction-complete pulse |
| abandon_o | output | 1 | One-cycle interrupt-abandon pulse |

## Verification
An error in the sequencer state shows up at the ports one cycle after the edge that caused it. A wrong state makes `pass_o` or `stall_o` hold at the wrong level, or places an outcome pulse one cycle early or late. A first-cycle marker that is set too long or cleared too early appears as a late cancel where none is due, or as a missing one, in the cycle right after the first Execute cycle. A mix-up in the priority of cancel, interrupt and handshake gives the wrong outcome pulse on the next edge. The directed scenarios sample on the exact cycle each pulse is due and also confirm it is absent on the cycles around it.

// File: rtl/cphs_pkg.sv
package cphs_pkg;

    localparam int HS_W = 2;

    typedef enum logic [HS_W-1:0] {
        HS_WAIT   = 2'b00,
        HS_GO     = 2'b01,
        HS_ABSENT = 2'b10,
        HS_LAST   = 2'b11
    } hs_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_XFER,
        ST_FINAL
    } seq_st_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_TRAP,
        EV_DONE,
        EV_ABANDON,
        EV_CANCEL
    } evt_e;

    // State reached from a handshake reply; ABSENT returns to idle.
    function automatic seq_st_e st_after(hs_e h);
        case (h)
            HS_WAIT: return ST_BUSY;
            HS_GO:   return ST_XFER;
            HS_LAST: return ST_FINAL;
            default: return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/cphs_ctrl.sv
module cphs_ctrl
    import cphs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_i,
    input  logic [HS_W-1:0] dec_hs_i,
    input  logic [HS_W-1:0] exe_hs_i,
    input  logic            irq_i,
    input  logic            prior_abort_i,
    output seq_st_e         st_o,
    output evt_e            ev_o
);

    seq_st_e st_q, st_nx;
    logic    first_q, first_nx;
    evt_e    ev;
    hs_e     dec_hs, exe_hs;

    assign dec_hs = hs_e'(dec_hs_i);
    assign exe_hs = hs_e'(exe_hs_i);

    always_comb begin
        st_nx    = st_q;
        first_nx = 1'b0;
        ev       = EV_NONE;
        if (st_q == ST_IDLE) begin
            if (issue_i) begin
                if (dec_hs == HS_ABSENT) begin
                    ev = EV_TRAP;
                end else begin
                    st_nx    = st_after(dec_hs);
                    first_nx = 1'b1;
                end
            end
        end else if (first_q && prior_abort_i) begin
            st_nx = ST_IDLE;
            ev    = EV_CANCEL;
        end else if (st_q == ST_BUSY && irq_i) begin
            st_nx = ST_IDLE;
            ev    = EV_ABANDON;
        end else if (st_q == ST_FINAL) begin
            st_nx = ST_IDLE;
            ev    = EV_DONE;
        end else begin
            st_nx = st_after(exe_hs);
            if (exe_hs == HS_ABSENT) ev = EV_TRAP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            first_q <= 1'b0;
        end else begin
            st_q    <= st_nx;
            first_q <= first_nx;
        end
    end

    assign st_o = st_q;
    assign ev_o = ev;

endmodule

// File: rtl/cphs_evt.sv
module cphs_evt
    import cphs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_e ev_i,
    output logic trap_o,
    output logic done_o,
    output logic abandon_o,
    output logic cancel_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_o    <= 1'b0;
            done_o    <= 1'b0;
            abandon_o <= 1'b0;
            cancel_o  <= 1'b0;
        end else begin
            trap_o    <= (ev_i == EV_TRAP);
            done_o    <= (ev_i == EV_DONE);
            abandon_o <= (ev_i == EV_ABANDON);
            cancel_o  <= (ev_i == EV_CANCEL);
        end
    end

    assert_events_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap_o, done_o, abandon_o, cancel_o}));

endmodule

// File: rtl/cphs_seq.sv
module cphs_seq
    import cphs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_i,
    input  logic [HS_W-1:0] dec_hs_i,
    input  logic [HS_W-1:0] exe_hs_i,
    input  logic            irq_i,
    input  logic            prior_abort_i,
    output logic            pass_o,
    output logic            stall_o,
    output logic            late_cancel_o,
    output logic            undef_trap_o,
    output logic            done_o,
    output logic            abandon_o
);

    seq_st_e st;
    evt_e    ev;

    cphs_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .issue_i       (issue_i),
        .dec_hs_i      (dec_hs_i),
        .exe_hs_i      (exe_hs_i),
        .irq_i         (irq_i),
        .prior_abort_i (prior_abort_i),
        .st_o          (st),
        .ev_o          (ev)
    );

    cphs_evt u_evt (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .trap_o    (undef_trap_o),
        .done_o    (done_o),
        .abandon_o (abandon_o),
        .cancel_o  (late_cancel_o)
    );

    assign pass_o  = (st != ST_IDLE);
    assign stall_o = (st == ST_BUSY);

    assert_stall_holds_pass_R2: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> pass_o);

    assert_done_after_final_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(pass_o) && !$past(stall_o) && !pass_o));

    assert_trap_drops_pass_R4: assert property (@(posedge clk) disable iff (rst)
        undef_trap_o |-> !pass_o);

    assert_abandon_from_wait_R5: assert property (@(posedge clk) disable iff (rst)
        abandon_o |-> ($past(stall_o) && !pass_o && !stall_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_cancel_ends_instr_R8: assert property (@(posedge clk) disable iff (rst)
        late_cancel_o |-> ($past(pass_o) && !pass_o));

    assert_cancel_no_done_R8: assert property (@(posedge clk) disable iff (rst)
        late_cancel_o |=> !done_o);

endmodule

// File: tb/tb_cphs_seq.sv
module tb_cphs_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic       issue_i;
    logic [1:0] dec_hs_i;
    logic [1:0] exe_hs_i;
    logic       irq_i;
    logic       prior_abort_i;
    logic       pass_o, stall_o, late_cancel_o, undef_trap_o, done_o, abandon_o;

    localparam logic [1:0] WAIT = 2'b00, GO = 2'b01, ABS = 2'b10, LAST = 2'b11;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cphs_seq dut (
        .clk (clk), .rst (rst), .issue_i (issue_i), .dec_hs_i (dec_hs_i),
        .exe_hs_i (exe_hs_i), .irq_i (irq_i), .prior_abort_i (prior_abort_i),
        .pass_o (pass_o), .stall_o (stall_o), .late_cancel_o (late_cancel_o),
        .undef_trap_o (undef_trap_o), .done_o (done_o), .abandon_o (abandon_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int outs();
        return {26'd0, pass_o, stall_o, late_cancel_o, undef_trap_o, done_o, abandon_o};
    endfunction

    task automatic idle_inputs();
        issue_i = 0; dec_hs_i = WAIT; exe_hs_i = WAIT; irq_i = 0; prior_abort_i = 0;
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs();
        step(); step();
        rst = 0;
        step();
        chk("R10 all outputs low after reset", outs(), 0);
    endtask

    task automatic t_dec_absent();
        issue_i = 1; dec_hs_i = ABS;
        step(); issue_i = 0;
        chk("R1 trap pulse after decode ABSENT", undef_trap_o, 1);
        chk("R1 pass low on trap", pass_o, 0);
        step();
        chk("R1 trap one cycle", undef_trap_o, 0);
    endtask

    task automatic t_busy_then_last();
        issue_i = 1; dec_hs_i = WAIT; exe_hs_i = WAIT;
        step(); issue_i = 0;
        for (int i = 0; i < 3; i++) begin
            chk("R2 stall during WAIT", stall_o, 1);
            chk("R2 pass during WAIT", pass_o, 1);
            if (i < 2) step();
        end
        exe_hs_i = LAST;
        step(); exe_hs_i = WAIT;
        chk("R3 final cycle pass", pass_o, 1);
        chk("R3 final cycle no stall", stall_o, 0);
        chk("R3 no early done", done_o, 0);
        step();
        chk("R3 done pulse", done_o, 1);
        chk("R3 pass low after done", pass_o, 0);
        step();
        chk("R3 done one cycle", done_o, 0);
    endtask

    task automatic t_exe_absent();
        issue_i = 1; dec_hs_i = GO; exe_hs_i = ABS;
        step(); issue_i = 0;
        chk("R4 transferring before ABSENT", pass_o, 1);
        step(); exe_hs_i = WAIT;
        chk("R4 trap after execute ABSENT", undef_trap_o, 1);
        chk("R4 pass low", pass_o, 0);
        step();
        chk("R4 no done after trap", done_o, 0);
    endtask

    task automatic t_irq_busy();
        issue_i = 1; dec_hs_i = WAIT; exe_hs_i = WAIT;
        step(); issue_i = 0;
        step();
        chk("R5 busy-waiting before irq", stall_o, 1);
        irq_i = 1;
        step(); irq_i = 0;
        chk("R5 abandon pulse", abandon_o, 1);
        chk("R5 pass low after irq", pass_o, 0);
        chk("R5 stall low after irq", stall_o, 0);
        chk("R5 no trap or done", undef_trap_o + done_o, 0);
        step();
        chk("R5 abandon one cycle", abandon_o, 0);
        chk("R5 no late done", done_o, 0);
    endtask

    task automatic t_irq_xfer();
        int dn = 0, ab = 0;
        issue_i = 1; dec_hs_i = GO; exe_hs_i = GO; irq_i = 1;
        step(); issue_i = 0;
        step(); exe_hs_i = LAST;
        for (int i = 0; i < 4; i++) begin
            step(); exe_hs_i = WAIT;
            dn += done_o; ab += abandon_o;
        end
        irq_i = 0;
        chk("R6 irq ignored during GO: done", dn, 1);
        chk("R6 irq ignored during GO: no abandon", ab, 0);
    endtask

    task automatic t_multi();
        int pc = 0, dn = 0;
        issue_i = 1; dec_hs_i = GO; exe_hs_i = GO;
        step(); issue_i = 0; pc += pass_o;
        step(); pc += pass_o;
        exe_hs_i = LAST;
        for (int i = 0; i < 6; i++) begin
            step(); exe_hs_i = WAIT;
            pc += pass_o; dn += done_o;
        end
        chk("R7 pass cycles for GO,GO,LAST", pc, 3);
        chk("R7 single done", dn, 1);
    endtask

    task automatic t_late_cancel();
        int dn = 0;
        issue_i = 1; dec_hs_i = WAIT; exe_hs_i = LAST;
        step(); issue_i = 0; prior_abort_i = 1;
        step(); prior_abort_i = 0;
        chk("R8 late cancel pulse", late_cancel_o, 1);
        chk("R8 pass low after cancel", pass_o, 0);
        chk("R8 stall low after cancel", stall_o, 0);
        for (int i = 0; i < 3; i++) begin
            step(); dn += done_o + undef_trap_o + abandon_o;
            if (i == 0) chk("R8 cancel one cycle", late_cancel_o, 0);
        end
        exe_hs_i = WAIT;
        chk("R8 no outcome after cancel", dn, 0);
    endtask

    task automatic t_late_abort_ignored();
        int lc = 0, dn = 0;
        issue_i = 1; dec_hs_i = GO; exe_hs_i = GO;
        step(); issue_i = 0;
        step(); prior_abort_i = 1; exe_hs_i = LAST;
        for (int i = 0; i < 4; i++) begin
            step(); exe_hs_i = WAIT; prior_abort_i = 0;
            lc += late_cancel_o; dn += done_o;
        end
        chk("R8 later abort ignored: no cancel", lc, 0);
        chk("R8 later abort ignored: done", dn, 1);
    endtask

    task automatic t_issue_ignored();
        issue_i = 1; dec_hs_i = WAIT; exe_hs_i = WAIT;
        step();
        dec_hs_i = ABS;
        step(); issue_i = 0;
        chk("R9 reissue ignored: no trap", undef_trap_o, 0);
        chk("R9 reissue ignored: still stalled", stall_o, 1);
        exe_hs_i = LAST;
        step(); exe_hs_i = WAIT;
        step();
        chk("R9 original instruction completes", done_o, 1);
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_dec_absent();
        t_busy_then_last();
        t_exe_absent();
        t_irq_busy();
        t_irq_xfer();
        t_multi();
        t_late_cancel();
        t_late_abort_ignored();
        t_issue_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule